// File: doc/BRIEF.md
# Iterative Word Dot-Product Accumulator

This block runs a four-pass multiply-accumulate over signed 16-bit words. A small internal register file holds 512-bit source vectors. A single 128-bit operand is copied into every 128-bit slice to form the second multiplicand. For every pass, each of the sixteen 32-bit accumulator lanes adds two products to its current value: its even-word product and its odd-word product. The result can either wrap or be clamped to the signed 32-bit range.

A caller first loads source vectors through the write port. It then pulses `start` with these inputs: a starting register index, the broadcast operand, the initial accumulator, a lane mask and the two mode bits. The unit reads four registers in consecutive passes, one pass per clock. The read index stays inside the aligned group of four that holds the starting index. After the last pass, the lane mask is applied. Masked-off lanes either keep their initial accumulator value or are cleared. The final vector is then presented together with a one-cycle `done` pulse.

Top module: `wdp_iter_acc`

## Requirements
- R1: Word k of the second multiplicand is word (k mod 8) of `bcast_op`, where word k occupies bits [16k+15:16k]. Accumulator lane i occupies bits [32i+31:32i] and pairs word 2i (even) with word 2i+1 (odd).
- R2: Products are exact signed 16x16 values, including (-32768)x(-32768) = +2^30.
- R3: In each pass, every lane takes its current value plus its even-word product plus its odd-word product as the new value.
- R4: Register file entry `rf_waddr` stores `rf_wdata` when `rf_we` is high. The four passes read the indices s, then s+1, s+2 and s+3, each taken modulo 4 inside the aligned group (s rounded down to a multiple of 4). For example, s=5 reads 5, 6, 7, 4.
- R5: With `sat_mode`=0, each pass stores the lane sum truncated to 32 bits.
- R6: With `sat_mode`=1, each pass clamps the lane sum to [-2^31, 2^31-1] before it is stored, and the clamp applies to the running value of every pass.
- R7: With `zero_mask`=0, a lane whose `lane_mask` bit is 0 returns its initial `acc_in` value.
- R8: With `zero_mask`=1, a lane whose `lane_mask` bit is 0 returns zero.
- R9: If `start` is accepted at clock edge E0, `done` is high for exactly the one cycle after edge E0+5, and `result` is valid in that cycle. `busy` is high from E0 until `done` rises.
- R10: A `start` while `busy` is high is ignored. The running operation and its result are unaffected, and no second operation follows.
- R11: After reset, `busy`, `done` and `result` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rf_we | input | 1 | Register file write enable |
| rf_waddr | input | 3 | Register file write index |
| rf_wdata | input | 512 | Register file write data |
| start | input | 1 | Begin an operation when idle |
| src_idx | input | 3 | Starting source register index |
| bcast_op | input | 128 | Operand replicated to every 128-bit slice |
| acc_in | input | 512 | Initial accumulator (destination) vector |
| lane_mask | input | 16 | Per-lane write enable for the final result |
| zero_mask | input | 1 | 1: clear masked lanes, 0: keep their initial value |
| sat_mode | input | 1 | 1: saturating accumulate, 0: wrapping |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| result | output | 512 | Final masked accumulator vector |

## Verification
The bench builds the unit with default parameters and a register file of eight entries. This gives two aligned groups, so every starting index 0 to 7 can be swept in both mask modes and both accumulate modes. The second group is loaded with extreme words: all -32768 and all +32767. This makes the saturation order observable, since a clamp in an early pass gives a different final value from a clamp applied only at the end. The first group checks the broadcast lane mapping with a one-hot-style pattern.

// File: rtl/wdp_pkg.sv
package wdp_pkg;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_RUN  = 2'd1,
      ST_FIN  = 2'd2
   } wdp_state_t;

endpackage

// File: rtl/wdp_regfile.sv
module wdp_regfile #(
   parameter int DEPTH = 8,
   parameter int WIDTH = 512,
   localparam int AW   = $clog2(DEPTH)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             we,
   input  logic [AW-1:0]    waddr,
   input  logic [WIDTH-1:0] wdata,
   input  logic [AW-1:0]    raddr,
   output logic [WIDTH-1:0] rdata
);

   logic [WIDTH-1:0] mem_q [DEPTH];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int k = 0; k < DEPTH; k++) mem_q[k] <= '0;
      end else if (we) begin
         mem_q[waddr] <= wdata;
      end
   end

   assign rdata = mem_q[raddr];

endmodule

// File: rtl/wdp_lane.sv
module wdp_lane #(
   parameter int WORD_W  = 16,
   parameter bit SAT_EN  = 1'b1,
   localparam int ACC_W  = 2 * WORD_W,
   localparam int SUM_W  = ACC_W + 2
) (
   input  logic signed [WORD_W-1:0] a_ev,
   input  logic signed [WORD_W-1:0] a_od,
   input  logic signed [WORD_W-1:0] b_ev,
   input  logic signed [WORD_W-1:0] b_od,
   input  logic        [ACC_W-1:0]  acc_cur,
   input  logic                     sat,
   output logic        [ACC_W-1:0]  acc_nxt
);

   localparam logic signed [SUM_W-1:0] MAXV = {{(SUM_W-ACC_W+1){1'b0}}, {(ACC_W-1){1'b1}}};
   localparam logic signed [SUM_W-1:0] MINV = {{(SUM_W-ACC_W+1){1'b1}}, {(ACC_W-1){1'b0}}};

   logic signed [ACC_W-1:0] p_ev, p_od;
   logic signed [SUM_W-1:0] sum;

   assign p_ev = a_ev * b_ev;
   assign p_od = a_od * b_od;
   assign sum  = {{2{p_ev[ACC_W-1]}}, p_ev}
               + {{2{p_od[ACC_W-1]}}, p_od}
               + {{2{acc_cur[ACC_W-1]}}, acc_cur};

   generate
      if (SAT_EN) begin : g_sat
         always_comb begin
            if (sat && (sum > MAXV))      acc_nxt = MAXV[ACC_W-1:0];
            else if (sat && (sum < MINV)) acc_nxt = MINV[ACC_W-1:0];
            else                          acc_nxt = sum[ACC_W-1:0];
         end
      end else begin : g_wrap
         assign acc_nxt = sum[ACC_W-1:0];
      end
   endgenerate

endmodule

// File: rtl/wdp_ctrl.sv
module wdp_ctrl
   import wdp_pkg::*;
#(
   parameter int NPASS  = 4,
   parameter int IDX_W  = 3,
   localparam int OFF_W = $clog2(NPASS),
   localparam int BASE_W = IDX_W - OFF_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [IDX_W-1:0] src_idx,
   output logic             busy,
   output logic             accept,
   output logic             run,
   output logic             fin,
   output logic             done,
   output logic [IDX_W-1:0] rd_idx
);

   wdp_state_t        st_q;
   logic [OFF_W-1:0]  off_q, cnt_q;
   logic [BASE_W-1:0] base_q;
   logic              done_q;

   assign busy   = (st_q != ST_IDLE);
   assign accept = start && (st_q == ST_IDLE);
   assign run    = (st_q == ST_RUN);
   assign fin    = (st_q == ST_FIN);
   assign done   = done_q;
   assign rd_idx = {base_q, off_q};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= ST_IDLE;
         off_q  <= '0;
         cnt_q  <= '0;
         base_q <= '0;
         done_q <= 1'b0;
      end else begin
         done_q <= (st_q == ST_FIN);
         unique case (st_q)
            ST_IDLE: if (start) begin
               base_q <= src_idx[IDX_W-1:OFF_W];
               off_q  <= src_idx[OFF_W-1:0];
               cnt_q  <= '0;
               st_q   <= ST_RUN;
            end
            ST_RUN: begin
               off_q <= off_q + 1'b1;
               cnt_q <= cnt_q + 1'b1;
               if (cnt_q == OFF_W'(NPASS-1)) st_q <= ST_FIN;
            end
            ST_FIN:  st_q <= ST_IDLE;
            default: st_q <= ST_IDLE;
         endcase
      end
   end

   AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && start) |=> $stable(base_q)); // R10
   AST_GROUP_WALK: assert property (@(posedge clk) disable iff (!rst_n)
      (run && $past(run)) |-> (rd_idx[IDX_W-1:OFF_W] == $past(rd_idx[IDX_W-1:OFF_W])
                               && rd_idx[OFF_W-1:0] == OFF_W'($past(rd_idx[OFF_W-1:0]) + 1'b1))); // R4
   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done); // R9
   AST_BUSY_ENDS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> done); // R9

endmodule

// File: rtl/wdp_iter_acc.sv
module wdp_iter_acc
   import wdp_pkg::*;
#(
   parameter int WORD_W   = 16,
   parameter int N_LANES  = 16,
   parameter int BCAST_W  = 128,
   parameter int NPASS    = 4,
   parameter int RF_DEPTH = 8,
   parameter bit SAT_EN   = 1'b1,
   localparam int ACC_W   = 2 * WORD_W,
   localparam int VEC_W   = N_LANES * ACC_W,
   localparam int IDX_W   = $clog2(RF_DEPTH),
   localparam int N_SLICE = VEC_W / BCAST_W
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               rf_we,
   input  logic [IDX_W-1:0]   rf_waddr,
   input  logic [VEC_W-1:0]   rf_wdata,
   input  logic               start,
   input  logic [IDX_W-1:0]   src_idx,
   input  logic [BCAST_W-1:0] bcast_op,
   input  logic [VEC_W-1:0]   acc_in,
   input  logic [N_LANES-1:0] lane_mask,
   input  logic               zero_mask,
   input  logic               sat_mode,
   output logic               busy,
   output logic               done,
   output logic [VEC_W-1:0]   result
);

   generate
      if (VEC_W % BCAST_W != 0) begin : g_bad_slice
         $error("vector width must be a multiple of the broadcast width");
      end
      if (BCAST_W % ACC_W != 0) begin : g_bad_bcast
         $error("broadcast width must hold whole lanes");
      end
      if ((NPASS < 2) || ((NPASS & (NPASS - 1)) != 0)) begin : g_bad_npass
         $error("pass count must be a power of two of at least 2");
      end
      if ((RF_DEPTH <= NPASS) || (RF_DEPTH % NPASS != 0) || ((RF_DEPTH & (RF_DEPTH - 1)) != 0)) begin : g_bad_depth
         $error("register file depth must be a power-of-two multiple of the pass count");
      end
   endgenerate

   logic             accept, run, fin;
   logic [IDX_W-1:0] rd_idx;
   logic [VEC_W-1:0] rd_data, b_vec, acc_q, orig_q, acc_nxt, fin_vec, result_q;
   logic [BCAST_W-1:0] op_q;
   logic [N_LANES-1:0] mask_q;
   logic             zm_q, sat_q;

   wdp_ctrl #(.NPASS(NPASS), .IDX_W(IDX_W)) u_ctrl (
      .clk    (clk),
      .rst_n  (rst_n),
      .start  (start),
      .src_idx(src_idx),
      .busy   (busy),
      .accept (accept),
      .run    (run),
      .fin    (fin),
      .done   (done),
      .rd_idx (rd_idx)
   );

   wdp_regfile #(.DEPTH(RF_DEPTH), .WIDTH(VEC_W)) u_rf (
      .clk  (clk),
      .rst_n(rst_n),
      .we   (rf_we),
      .waddr(rf_waddr),
      .wdata(rf_wdata),
      .raddr(rd_idx),
      .rdata(rd_data)
   );

   generate
      for (genvar s = 0; s < N_SLICE; s++) begin : g_bcast
         assign b_vec[s*BCAST_W +: BCAST_W] = op_q;
      end

      for (genvar i = 0; i < N_LANES; i++) begin : g_lane
         wdp_lane #(.WORD_W(WORD_W), .SAT_EN(SAT_EN)) u_lane (
            .a_ev   (rd_data[(2*i)*WORD_W +: WORD_W]),
            .a_od   (rd_data[(2*i+1)*WORD_W +: WORD_W]),
            .b_ev   (b_vec[(2*i)*WORD_W +: WORD_W]),
            .b_od   (b_vec[(2*i+1)*WORD_W +: WORD_W]),
            .acc_cur(acc_q[i*ACC_W +: ACC_W]),
            .sat    (sat_q),
            .acc_nxt(acc_nxt[i*ACC_W +: ACC_W])
         );

         assign fin_vec[i*ACC_W +: ACC_W] = mask_q[i] ? acc_q[i*ACC_W +: ACC_W]
                                          : (zm_q ? '0 : orig_q[i*ACC_W +: ACC_W]);

         AST_ZERO_FILL: assert property (@(posedge clk) disable iff (!rst_n)
            (done && zm_q && !mask_q[i]) |-> (result[i*ACC_W +: ACC_W] == '0)); // R8
         AST_MERGE_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
            (done && !zm_q && !mask_q[i]) |-> (result[i*ACC_W +: ACC_W] == orig_q[i*ACC_W +: ACC_W])); // R7
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc_q    <= '0;
         orig_q   <= '0;
         op_q     <= '0;
         mask_q   <= '0;
         zm_q     <= 1'b0;
         sat_q    <= 1'b0;
         result_q <= '0;
      end else begin
         if (accept) begin
            acc_q  <= acc_in;
            orig_q <= acc_in;
            op_q   <= bcast_op;
            mask_q <= lane_mask;
            zm_q   <= zero_mask;
            sat_q  <= sat_mode;
         end else if (run) begin
            acc_q <= acc_nxt;
         end
         if (fin) result_q <= fin_vec;
      end
   end

   assign result = result_q;

   AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !done && !$past(fin)) |-> $stable(result)); // R9

endmodule

// File: tb/wdp_iter_acc_bench.sv
`timescale 1ns/1ps
module wdp_iter_acc_bench;

   localparam int VEC_W = 512;
   localparam int NL    = 16;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             rf_we = 1'b0;
   logic [2:0]       rf_waddr = '0;
   logic [VEC_W-1:0] rf_wdata = '0;
   logic             start = 1'b0;
   logic [2:0]       src_idx = '0;
   logic [127:0]     bcast_op = '0;
   logic [VEC_W-1:0] acc_in = '0;
   logic [NL-1:0]    lane_mask = '0;
   logic             zero_mask = 1'b0;
   logic             sat_mode = 1'b0;
   logic             busy, done;
   logic [VEC_W-1:0] result;

   int n_tests = 0;
   int n_fail  = 0;
   logic [VEC_W-1:0] reg_m [8];

   always #2 clk = ~clk;

   wdp_iter_acc #(.RF_DEPTH(8)) u_wdp_iter_acc (
      .clk(clk), .rst_n(rst_n), .rf_we(rf_we), .rf_waddr(rf_waddr), .rf_wdata(rf_wdata),
      .start(start), .src_idx(src_idx), .bcast_op(bcast_op), .acc_in(acc_in),
      .lane_mask(lane_mask), .zero_mask(zero_mask), .sat_mode(sat_mode),
      .busy(busy), .done(done), .result(result)
   );

   task automatic chk(input string tag, input logic [VEC_W-1:0] act, input logic [VEC_W-1:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic logic [VEC_W-1:0] rnd_vec();
      logic [VEC_W-1:0] v;
      for (int k = 0; k < VEC_W/32; k++) v[k*32 +: 32] = $urandom;
      return v;
   endfunction

   function automatic logic [VEC_W-1:0] fill_words(input logic [15:0] w);
      logic [VEC_W-1:0] v;
      for (int k = 0; k < VEC_W/16; k++) v[k*16 +: 16] = w;
      return v;
   endfunction

   function automatic logic [VEC_W-1:0] model(input int idx, input logic [127:0] op,
         input logic [VEC_W-1:0] acc, input logic [NL-1:0] msk, input bit zm, input bit sat);
      longint lane [NL];
      logic [VEC_W-1:0] out;
      for (int i = 0; i < NL; i++) lane[i] = longint'($signed(acc[i*32 +: 32]));
      for (int p = 0; p < 4; p++) begin
         int r;
         r = (idx & ~3) | ((idx + p) & 3);
         for (int i = 0; i < NL; i++) begin
            longint s;
            s = lane[i]
              + longint'($signed(reg_m[r][(2*i)*16 +: 16]))   * longint'($signed(op[((2*i)%8)*16 +: 16]))
              + longint'($signed(reg_m[r][(2*i+1)*16 +: 16])) * longint'($signed(op[((2*i+1)%8)*16 +: 16]));
            if (sat) begin
               if (s > 64'sd2147483647) s = 64'sd2147483647;
               if (s < -64'sd2147483648) s = -64'sd2147483648;
            end else begin
               s = longint'($signed(s[31:0]));
            end
            lane[i] = s;
         end
      end
      for (int i = 0; i < NL; i++) begin
         if (msk[i])   out[i*32 +: 32] = lane[i][31:0];
         else if (zm)  out[i*32 +: 32] = '0;
         else          out[i*32 +: 32] = acc[i*32 +: 32];
      end
      return out;
   endfunction

   task automatic rf_write(input int idx, input logic [VEC_W-1:0] d);
      rf_we = 1'b1; rf_waddr = 3'(idx); rf_wdata = d; reg_m[idx] = d;
      @(negedge clk);
      rf_we = 1'b0;
   endtask

   task automatic run_op(input int idx, input logic [127:0] op, input logic [VEC_W-1:0] acc,
         input logic [NL-1:0] msk, input bit zm, input bit sat, input string tag,
         output logic [VEC_W-1:0] res);
      src_idx = 3'(idx); bcast_op = op; acc_in = acc; lane_mask = msk;
      zero_mask = zm; sat_mode = sat; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      chk({tag, " R9 busy after accept"}, VEC_W'(busy), VEC_W'(1));
      repeat (4) @(negedge clk);
      chk({tag, " R9 done not early"}, VEC_W'(done), VEC_W'(0));
      @(negedge clk);
      chk({tag, " R9 done at E0+5"}, VEC_W'(done), VEC_W'(1));
      res = result;
      @(negedge clk);
      chk({tag, " R9 done single cycle"}, VEC_W'(done), VEC_W'(0));
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      n_tests++; n_fail++;
      $display("FAIL R9 watchdog expired actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin : main
      logic [VEC_W-1:0] res, exp, acc;
      logic [127:0] op;
      logic [15:0] mw [8];

      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R11 reset state
      chk("R11 busy", VEC_W'(busy), '0);
      chk("R11 done", VEC_W'(done), '0);
      chk("R11 result", result, '0);

      // R1 broadcast mapping: reg0 all words 1, rest of group zero
      rf_write(0, fill_words(16'd1));
      for (int r = 1; r < 8; r++) rf_write(r, '0);
      for (int j = 0; j < 8; j++) mw[j] = (j % 2 == 1) ? 16'(-(j * 1000)) : 16'(j * 1000 + 3);
      for (int j = 0; j < 8; j++) op[j*16 +: 16] = mw[j];
      for (int i = 0; i < NL; i++) acc[i*32 +: 32] = 32'(i * 5);
      for (int i = 0; i < NL; i++)
         exp[i*32 +: 32] = 32'(i * 5 + int'($signed(mw[(2*i)%8])) + int'($signed(mw[(2*i+1)%8])));
      run_op(2, op, acc, '1, 1'b0, 1'b0, "R1 R3", res);
      chk("R1 R3 broadcast lane mapping", res, exp);

      // Extreme group: reg4 all -32768, reg5 all +32767, reg6/7 zero
      rf_write(4, fill_words(16'h8000));
      rf_write(5, fill_words(16'h7FFF));
      op = {8{16'h8000}};

      // R2 R5 wrapping: +2^31 wraps, then -2147418112 gives 65536
      run_op(4, op, '0, '1, 1'b0, 1'b0, "R2 R5", res);
      chk("R2 R5 exact product wrap", res, {NL{32'd65536}});

      // R6 clamp per pass, start 4: MAX clamps, then down to 65535
      run_op(4, op, {NL{32'h7FFFFFFF}}, '1, 1'b0, 1'b1, "R6", res);
      chk("R2 R6 per-pass clamp high", res, {NL{32'd65535}});
      // R4 order: start 5 walks 5,6,7,4 and ends clamped at MAX
      run_op(5, op, {NL{32'h7FFFFFFF}}, '1, 1'b0, 1'b1, "R4 R6", res);
      chk("R4 R6 wrap order in group", res, {NL{32'h7FFFFFFF}});
      // R6 low clamp: start 5 from MIN clamps, then +2^31 gives 0
      run_op(5, op, {NL{32'h80000000}}, '1, 1'b0, 1'b1, "R6", res);
      chk("R6 per-pass clamp low", res, '0);

      // R4 random register contents, full sweep of index and modes
      for (int r = 0; r < 4; r++) rf_write(r, rnd_vec());
      for (int idx = 0; idx < 8; idx++) begin
         for (int sat = 0; sat < 2; sat++) begin
            for (int zm = 0; zm < 2; zm++) begin
               logic [NL-1:0] msk;
               string tag;
               msk = 16'hA5C3 ^ 16'(idx * 16'h1111) ^ 16'(sat * 16'h0F0F);
               op  = {$urandom, $urandom, $urandom, $urandom};
               acc = rnd_vec();
               tag = $sformatf("R3 R4 %s %s idx=%0d", sat ? "R6" : "R5", zm ? "R8" : "R7", idx);
               run_op(idx, op, acc, msk, zm[0], sat[0], tag, res);
               chk(tag, res, model(idx, op, acc, msk, zm[0], sat[0]));
            end
         end
      end

      // R10 start while busy is ignored
      op = {$urandom, $urandom, $urandom, $urandom};
      acc = rnd_vec();
      exp = model(1, op, acc, 16'hFFFF, 1'b0, 1'b0);
      src_idx = 3'd1; bcast_op = op; acc_in = acc; lane_mask = '1;
      zero_mask = 1'b0; sat_mode = 1'b0; start = 1'b1;
      @(negedge clk);
      src_idx = 3'd6; bcast_op = ~op; acc_in = ~acc; lane_mask = '0;
      zero_mask = 1'b1; sat_mode = 1'b1;
      repeat (2) @(negedge clk);
      start = 1'b0;
      repeat (2) @(negedge clk);
      chk("R10 done timing", VEC_W'(done), '0);
      @(negedge clk);
      chk("R10 done after first op", VEC_W'(done), VEC_W'(1));
      chk("R10 result unaffected", result, exp);
      @(negedge clk);
      chk("R10 no second op", VEC_W'(busy), '0);
      repeat (6) @(negedge clk);
      chk("R10 no second done", VEC_W'(done), '0);
      chk("R10 result held", result, exp);

      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule